// File: doc/BRIEF.md
# Grouped shared interrupt aggregator

This block gathers twenty-two peripheral interrupt sources into sticky pending bits and sorts them into four fixed groups, each of which drives one line toward a parent interrupt controller. Every source input passes through a synchronizer. A rising edge on the synchronized level sets the matching pending bit. A group line is raised while any pending bit of that group is set and allowed through.

Software sees the block through a small 32-bit register bus. The pending bits are read at offset 0x04, and a write to that same offset clears every bit written as zero. A mask register at offset 0x08 applies only to the first group: a bit that is cleared lets the source through, and a bit that is set blocks it. A service routine reads status, trims the value to its group's bit range, clears what it has handled and repeats until the range is empty. For that loop to work, a source that fires again during service must show up again.

Top module: `irq_group_agg`

## Requirements
- R1: A rising edge on a synchronized source sets its pending bit, which then stays set until software clears it, whatever the source level does.
- R2: A write to offset 0x04 clears each pending bit whose data bit is 0 and leaves each pending bit whose data bit is 1 unchanged.
- R3: When a new edge and a clearing write hit the same pending bit in the same cycle, the bit ends up set.
- R4: A read of offset 0x04 returns pending bits 0 to 21, and bits 22 to 31 read as 0.
- R5: The mask register at offset 0x08 holds bits 0 to 6, resets to 0x7F, and reads back its value with bits 7 to 31 as 0. Writes to bits 7 to 31 have no effect.
- R6: `irq_grp[0]` (sources 0 to 6) is the OR of the pending bits whose mask bit is 0, and it is valid one cycle after the pending state.
- R7: `irq_grp[1]` (sources 7 to 9), `irq_grp[2]` (source 10) and `irq_grp[3]` (sources 11 to 21) are the plain OR of their pending bits, one cycle after the pending state, and have no mask.
- R8: Setting a mask bit gates only the group line. The pending bit stays set and still reads as 1 in status.
- R9: After reset all pending bits, all group lines and the read data are 0.
- R10: A source held high after its bit is cleared does not set the bit again. A fresh rising edge after a clear sets it again.
- R11: Reads of any offset other than 0x04 and 0x08 return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src | input | 22 | Asynchronous peripheral interrupt levels |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after a read strobe |
| irq_grp | output | 4 | Registered parent interrupt lines, one per group |

## Verification
The sharpest corner is an edge that lands in the same cycle as a clearing write. The bench times a source edge to coincide exactly with an all-zero clear. A design that lets the clear win would lose that interrupt for good, and status would read 0 in place of the expected bit. Masking is checked both ways: a design that cleared pending on mask would drop the bit from status, and one that applied the mask to the other groups would silence their lines. The clear register's active-low polarity is exercised with all-ones writes (nothing may change) and single-zero writes (exactly one bit drops). A source held high across a clear catches a level-sensitive design, which would set the bit again at once. Writes to the mask's unused bits and to undecoded offsets catch decode that is too loose.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  localparam int NUM_SRC  = 22;
  localparam int GRP_CNT  = 4;
  localparam int MASK_GRP = 0;   // only this group has mask bits; it starts at bit 0

  localparam int GRP_BASE [GRP_CNT] = '{0, 7, 10, 11};
  localparam int GRP_SIZE [GRP_CNT] = '{7, 3, 1, 11};

  // Bit vector selecting the sources that belong to group g
  function automatic logic [NUM_SRC-1:0] grp_mask(input int g);
    logic [NUM_SRC-1:0] m;
    m = '0;
    for (int b = 0; b < NUM_SRC; b++) begin
      if (b >= GRP_BASE[g] && b < GRP_BASE[g] + GRP_SIZE[g]) m[b] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/irq_edge_capture.sv
module irq_edge_capture #(
  parameter int N      = 22,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] src_i,
  output logic [N-1:0] rise_o
);

  logic [N-1:0] sync_q [STAGES];
  logic [N-1:0] last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) sync_q[s] <= '0;
      last_q <= '0;
    end else begin
      sync_q[0] <= src_i;
      for (int s = 1; s < STAGES; s++) sync_q[s] <= sync_q[s-1];
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int N = 22
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic         clr_we_i,
  input  logic [N-1:0] keep_i,   // 0 = clear this bit, 1 = keep
  output logic [N-1:0] pend_o
);

  logic [N-1:0] pend_q;
  logic [N-1:0] keep_w;

  assign keep_w = clr_we_i ? keep_i : '1;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (pend_q & keep_w) | set_i;   // a new edge beats the clear
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/irq_group_or.sv
module irq_group_or
  import irq_agg_pkg::*;
#(
  parameter int N    = NUM_SRC,
  parameter int EN_W = GRP_SIZE[MASK_GRP]
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N-1:0]       pend_i,
  input  logic [EN_W-1:0]    en_n_i,
  output logic [GRP_CNT-1:0] grp_o
);

  logic [N-1:0]       en_gate;
  logic [GRP_CNT-1:0] any_w;
  logic [GRP_CNT-1:0] grp_q;

  assign en_gate = {{(N-EN_W){1'b1}}, ~en_n_i};

  for (genvar g = 0; g < GRP_CNT; g++) begin : g_grp
    logic [N-1:0] hit;
    if (g == MASK_GRP) begin : g_masked
      assign hit = pend_i & grp_mask(g) & en_gate;
    end else begin : g_open
      assign hit = pend_i & grp_mask(g);
    end
    assign any_w[g] = |hit;
  end

  always_ff @(posedge clk) begin
    if (rst) grp_q <= '0;
    else     grp_q <= any_w;
  end

  assign grp_o = grp_q;

endmodule

// File: rtl/irq_regs.sv
module irq_regs #(
  parameter int                DATA_W  = 32,
  parameter int                ADDR_W  = 4,
  parameter int                N       = 22,
  parameter int                EN_W    = 7,
  parameter logic [ADDR_W-1:0] STS_OFS = 4'h4,
  parameter logic [ADDR_W-1:0] EN_OFS  = 4'h8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [N-1:0]      pend_i,
  output logic              clr_we_o,
  output logic [N-1:0]      keep_o,
  output logic [EN_W-1:0]   en_n_o,
  output logic [DATA_W-1:0] rdata_o
);

  logic [EN_W-1:0]   en_n_q;
  logic [DATA_W-1:0] rdata_q;
  logic              en_we;
  logic              unused_wdata_bits;

  assign clr_we_o = sel_i & wr_i & (addr_i == STS_OFS);
  assign en_we    = sel_i & wr_i & (addr_i == EN_OFS);
  assign keep_o   = wdata_i[N-1:0];
  assign unused_wdata_bits = ^wdata_i[DATA_W-1:N];

  always_ff @(posedge clk) begin
    if (rst)        en_n_q <= '1;
    else if (en_we) en_n_q <= wdata_i[EN_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (sel_i && !wr_i) begin
      case (addr_i)
        STS_OFS: rdata_q <= DATA_W'(pend_i);
        EN_OFS:  rdata_q <= DATA_W'(en_n_q);
        default: rdata_q <= '0;
      endcase
    end
  end

  assign en_n_o  = en_n_q;
  assign rdata_o = rdata_q;

endmodule

// File: rtl/irq_group_agg.sv
module irq_group_agg
  import irq_agg_pkg::*;
#(
  parameter int                DATA_W      = 32,
  parameter int                ADDR_W      = 4,
  parameter int                SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] STS_OFS     = 4'h4,
  parameter logic [ADDR_W-1:0] EN_OFS      = 4'h8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_src,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic [GRP_CNT-1:0] irq_grp
);

  localparam int EN_W = GRP_SIZE[MASK_GRP];

  logic [NUM_SRC-1:0] rise_w;
  logic [NUM_SRC-1:0] pend_q;
  logic [NUM_SRC-1:0] keep_w;
  logic               clr_we;
  logic [EN_W-1:0]    en_n_w;

  irq_edge_capture #(.N(NUM_SRC), .STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .src_i(irq_src), .rise_o(rise_w)
  );

  irq_pend_bank #(.N(NUM_SRC)) u_pend (
    .clk(clk), .rst(rst), .set_i(rise_w), .clr_we_i(clr_we),
    .keep_i(keep_w), .pend_o(pend_q)
  );

  irq_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .N(NUM_SRC), .EN_W(EN_W),
    .STS_OFS(STS_OFS), .EN_OFS(EN_OFS)
  ) u_regs (
    .clk(clk), .rst(rst), .sel_i(bus_sel), .wr_i(bus_wr), .addr_i(bus_addr),
    .wdata_i(bus_wdata), .pend_i(pend_q), .clr_we_o(clr_we), .keep_o(keep_w),
    .en_n_o(en_n_w), .rdata_o(bus_rdata)
  );

  irq_group_or #(.N(NUM_SRC), .EN_W(EN_W)) u_grp (
    .clk(clk), .rst(rst), .pend_i(pend_q), .en_n_i(en_n_w), .grp_o(irq_grp)
  );

endmodule

// File: rtl/irq_group_agg_chk.sv
module irq_group_agg_chk
  import irq_agg_pkg::*;
#(
  parameter int                DATA_W  = 32,
  parameter int                ADDR_W  = 4,
  parameter int                EN_W    = 7,
  parameter logic [ADDR_W-1:0] STS_OFS = 4'h4,
  parameter logic [ADDR_W-1:0] EN_OFS  = 4'h8
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      bus_sel,
  input logic                      bus_wr,
  input logic [ADDR_W-1:0]         bus_addr,
  input logic [NUM_SRC-1:0]        wdata_lo,
  input logic [DATA_W-1:NUM_SRC]   rdata_hi,
  input logic [NUM_SRC-1:0]        pend,
  input logic [NUM_SRC-1:0]        rise,
  input logic [EN_W-1:0]           en_n,
  input logic [GRP_CNT-1:0]        irq_grp
);

  logic clr_wr, en_wr;
  assign clr_wr = bus_sel & bus_wr & (bus_addr == STS_OFS);
  assign en_wr  = bus_sel & bus_wr & (bus_addr == EN_OFS);

  // R1: without a clearing write no pending bit falls
  assert_sticky_R1: assert property (@(posedge clk) disable iff (rst)
    !clr_wr |=> ((pend & $past(pend)) == $past(pend)));

  // R2: a bit written as 0 and not newly set is cleared
  assert_clear_zero_R2: assert property (@(posedge clk) disable iff (rst)
    clr_wr |=> ((pend & ~$past(wdata_lo) & ~$past(rise)) == '0));

  // R3: every edge lands in pending, even during a clear
  assert_set_wins_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend & $past(rise)) == $past(rise)));

  // R4: unused status bits stay zero
  assert_upper_zero_R4: assert property (@(posedge clk) disable iff (rst)
    rdata_hi == '0);

  // R5: the mask register changes only on its own write
  assert_mask_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !en_wr |=> $stable(en_n));

  // R6: the masked group line follows enabled pending bits
  assert_grp_masked_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_grp[MASK_GRP] == $past(|(pend & grp_mask(MASK_GRP) & {{(NUM_SRC-EN_W){1'b0}}, ~en_n}))));

  // R7: the open group lines follow their pending bits
  assert_grp_b_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_grp[1] == $past(|(pend & grp_mask(1)))));
  assert_grp_c_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_grp[2] == $past(|(pend & grp_mask(2)))));
  assert_grp_d_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_grp[3] == $past(|(pend & grp_mask(3)))));

endmodule

bind irq_group_agg irq_group_agg_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .EN_W(EN_W), .STS_OFS(STS_OFS), .EN_OFS(EN_OFS)
) u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .wdata_lo(bus_wdata[NUM_SRC-1:0]), .rdata_hi(bus_rdata[DATA_W-1:NUM_SRC]),
  .pend(pend_q), .rise(rise_w), .en_n(en_n_w), .irq_grp(irq_grp)
);

// File: tb/irq_group_agg_bench.sv
`timescale 1ns/1ps
module irq_group_agg_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [21:0] irq_src = '0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  irq_grp;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_group_agg u_irq_group_agg (
    .clk(clk), .rst(rst), .irq_src(irq_src), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_grp(irq_grp)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic fire(input int idx);
    @(negedge clk);
    irq_src[idx] = 1'b1;
    tick(2);
    irq_src[idx] = 1'b0;
    tick(3);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R9 grp after reset", {28'b0, irq_grp}, 32'h0);
    chk("R9 rdata after reset", bus_rdata, 32'h0);
    bus_read(4'h4, d);  chk("R9 status after reset", d, 32'h0);
    bus_read(4'h8, d);  chk("R5 mask reset value", d, 32'h0000_007F);
  endtask

  task automatic t_capture_mask();
    logic [31:0] d;
    fire(3); fire(8); fire(10); fire(15);
    bus_read(4'h4, d);  chk("R1 R4 status after edges", d, 32'h0000_8508);
    chk("R7 open groups up, R6 masked group down", {28'b0, irq_grp}, 32'hE);
    bus_write(4'h8, 32'h0000_0077); tick(2);
    chk("R6 unmasked bit3 raises group line", {28'b0, irq_grp}, 32'hF);
    bus_write(4'h8, 32'h0000_007F); tick(2);
    chk("R8 mask drops line", {28'b0, irq_grp}, 32'hE);
    bus_read(4'h4, d);  chk("R8 masked bit still pending", d, 32'h0000_8508);
    bus_write(4'h8, 32'hFFFF_FF00);
    bus_read(4'h8, d);  chk("R5 upper mask bits ignored", d, 32'h0000_0000);
    tick(2);
    chk("R6 all-enabled group line", {28'b0, irq_grp}, 32'hF);
    bus_write(4'h8, 32'hFFFF_FFFF);
    bus_read(4'h8, d);  chk("R5 mask readback", d, 32'h0000_007F);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    bus_write(4'h4, 32'hFFFF_FFFF);
    bus_read(4'h4, d);  chk("R2 ones keep pending", d, 32'h0000_8508);
    bus_write(4'h4, 32'hFFFF_FEFF); tick(1);
    bus_read(4'h4, d);  chk("R2 zero clears bit8", d, 32'h0000_8408);
    chk("R7 group B drops after clear", {28'b0, irq_grp}, 32'hC);
    bus_write(4'h4, 32'h0); tick(1);
    bus_read(4'h4, d);  chk("R2 clear all", d, 32'h0);
    chk("R7 all lines low", {28'b0, irq_grp}, 32'h0);
  endtask

  task automatic t_set_wins();
    logic [31:0] d;
    fire(20);
    @(negedge clk);
    irq_src[12] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    bus_write(4'h4, 32'h0);          // clearing edge coincides with the set
    bus_read(4'h4, d);  chk("R3 set beats clear", d, 32'h0000_1000);
    bus_write(4'h4, 32'h0); tick(4); // source still high
    bus_read(4'h4, d);  chk("R10 held level does not re-set", d, 32'h0);
    irq_src[12] = 1'b0; tick(2);
    fire(12);
    bus_read(4'h4, d);  chk("R10 new edge sets again", d, 32'h0000_1000);
    chk("R7 group D up", {28'b0, irq_grp}, 32'h8);
    bus_write(4'h4, 32'h0);
  endtask

  task automatic t_refire_service();
    logic [31:0] d;
    fire(5);
    bus_read(4'h4, d);  chk("R1 group A source captured", d, 32'h0000_0020);
    fire(5);                          // re-fires before service clears
    bus_write(4'h4, ~32'h0000_0020);
    fire(5);                          // re-fires after the clear
    bus_read(4'h4, d);  chk("R10 re-fire visible again", d, 32'h0000_0020);
  endtask

  task automatic t_decode();
    logic [31:0] d;
    bus_write(4'hC, 32'h0);
    bus_write(4'h0, 32'h0);
    bus_read(4'h4, d);  chk("R11 stray writes ignored", d, 32'h0000_0020);
    bus_read(4'h8, d);  chk("R11 mask unchanged by stray writes", d, 32'h0000_007F);
    bus_read(4'hC, d);  chk("R11 undecoded read zero", d, 32'h0);
    bus_read(4'h0, d);  chk("R11 offset 0 reads zero", d, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_capture_mask();
    t_clear();
    t_set_wins();
    t_refire_service();
    t_decode();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule